// File: doc/BRIEF.md
# Row-parallel resistive array scanner

This block reads a two-dimensional array of resistive sensing units. Each unit has its own row-select pin, and all units in one column share a single capacitor. The block measures one whole row at a time. First it charges every column capacitor. Then it releases the charge pins and pulls the selected row low, so that each column capacitor discharges through the sensor of that row. One timer per column counts clock cycles until that column's threshold input goes low. The count is proportional to the sensor resistance.

The block steps through the rows in ascending order. An optional extra row of known reference resistors is scanned last, like any other row, so that downstream logic can calibrate the results. After each discharge the captured counts leave on a valid/ready stream, one column per beat, tagged with their row and column indices. The next row is not charged until the last beat of the current row has been accepted. At the end of a frame a one-cycle pulse marks completion. In continuous mode the scan then restarts at row 0; otherwise the block waits for a new start.

All pin controls are output enables. An enabled charge pin drives logic 1, and an enabled row-select pin drives logic 0. The column threshold inputs must already be synchronous to `clk`.

Top module: `rarray_scan`

## Requirements
- R1: While reset is asserted, and afterwards until `start` is seen, all charge and row enables are 0, `m_valid` is 0 and `frame_done` is 0. This also holds when reset hits in the middle of a frame.
- R2: In the charge phase every `col_oe` bit is 1 and every `row_oe` bit is 0. The phase lasts exactly CHARGE_CYCLES clock cycles.
- R3: In the discharge phase every `col_oe` bit is 0. Exactly one `row_oe` bit is 1: bit r, where r is the row being measured.
- R4: All column timers start together at the first discharge cycle. A column's count is the number of discharge-cycle clock edges at which its `col_in` was still 1 before the first edge at which it was 0. A column already low at the first edge reports 0.
- R5: A column whose `col_in` stays 1 for TIMEOUT discharge edges reports a count with all bits 1 and `m_timeout` = 1. A captured column reports `m_timeout` = 0.
- R6: After each discharge, COLS beats are sent for that row: `m_col` runs from 0 to COLS-1 and `m_row` carries the row index. Rows run in ascending order starting at 0.
- R7: While `m_valid` is 1 and `m_ready` is 0, the fields `m_row`, `m_col`, `m_count` and `m_timeout` hold steady. No new charge phase starts until the row's last beat is accepted.
- R8: `frame_done` is 1 for exactly one cycle: the cycle right after the last beat of the last row is accepted. It is 0 at all other times.
- R9: At the end of a frame, the block starts the row 0 charge phase if `continuous` is 1. If `continuous` is 0 it goes idle, with all enables 0, until the next `start`.
- R10: `start` has no effect while a frame is in progress.
- R11: With HAS_REF = 1, the reference row is scanned with row index ROWS, as the last row of each frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a frame when idle |
| continuous | input | 1 | Restart at row 0 after the last row |
| col_in | input | COLS | Column threshold inputs, 1 = above threshold, synchronous |
| col_oe | output | COLS | Charge-pin enables, an enabled pin drives 1 |
| row_oe | output | ROWS+HAS_REF | Row-select enables, an enabled pin drives 0 |
| m_valid | output | 1 | Result beat valid |
| m_ready | input | 1 | Result beat accepted when high with m_valid |
| m_row | output | clog2(ROWS+HAS_REF) | Row index of the beat |
| m_col | output | clog2(COLS) | Column index of the beat |
| m_count | output | TW | Discharge count, all ones on timeout |
| m_timeout | output | 1 | Column never crossed threshold |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with ROWS = 3 plus the reference row, COLS = 4, TW = 8, CHARGE_CYCLES = 3 and TIMEOUT = 20. These values make a full frame short, and they let the discharge delays in the table reach 0, TIMEOUT-1, exactly TIMEOUT and beyond it. The bench can therefore see both the capture edge and the saturation to 255 with the timeout flag. A behavioural column model discharges only through the row that is actually driven low, so a wrong row shows up as wrong counts. One row in which every column captures early exercises the early end of the discharge phase. Stalls from the ready pattern, continuous frames and a reset in the middle of a frame cover the stream, the frame looping and the return to idle.

// File: rtl/rscan_pkg.sv
package rscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_DISCH  = 2'd2,
    ST_OUT    = 2'd3
  } scan_st_e;

  // width of an index into n items, never below one bit
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rscan_col_timer.sv
module rscan_col_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          below,
  output logic [TW-1:0] cnt,
  output logic          hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      hit <= 1'b0;
    end else if (en && !hit) begin
      if (below) hit <= 1'b1;
      else       cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rscan_ctrl.sv
module rscan_ctrl
  import rscan_pkg::*;
#(
  parameter int NROWS         = 9,
  parameter int COLS          = 8,
  parameter int CHARGE_CYCLES = 64,
  parameter int TIMEOUT       = 60000,
  localparam int RW = idx_width(NROWS),
  localparam int CW = idx_width(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          continuous,
  input  logic          all_hit,
  input  logic          beat_fire,
  output scan_st_e      state,
  output logic [RW-1:0] cur_row,
  output logic [CW-1:0] cur_col,
  output logic          tmr_clr,
  output logic          tmr_en,
  output logic          frame_done
);

  localparam int PMAX = (CHARGE_CYCLES > TIMEOUT) ? CHARGE_CYCLES : TIMEOUT;
  localparam int PW   = $clog2(PMAX + 1);
  localparam logic [PW-1:0] CHG_END  = PW'(CHARGE_CYCLES - 1);
  localparam logic [PW-1:0] TO_END   = PW'(TIMEOUT - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(NROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_row    <= '0;
      cur_col    <= '0;
      pcnt       <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_CHARGE;
            cur_row <= '0;
            pcnt    <= '0;
          end
        end
        ST_CHARGE: begin
          if (pcnt == CHG_END) begin
            state <= ST_DISCH;
            pcnt  <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_DISCH: begin
          if (all_hit || pcnt == TO_END) begin
            state   <= ST_OUT;
            cur_col <= '0;
            pcnt    <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        ST_OUT: begin
          if (beat_fire) begin
            if (cur_col == COL_LAST) begin
              cur_col <= '0;
              if (cur_row == ROW_LAST) begin
                cur_row    <= '0;
                frame_done <= 1'b1;
                state      <= continuous ? ST_CHARGE : ST_IDLE;
              end else begin
                cur_row <= cur_row + 1'b1;
                state   <= ST_CHARGE;
              end
            end else begin
              cur_col <= cur_col + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tmr_clr = (state == ST_CHARGE);
  assign tmr_en  = (state == ST_DISCH);

endmodule

// File: rtl/rscan_pins.sv
module rscan_pins
  import rscan_pkg::*;
#(
  parameter int COLS  = 8,
  parameter int NROWS = 9,
  localparam int RW = idx_width(NROWS)
) (
  input  scan_st_e         state,
  input  logic [RW-1:0]    cur_row,
  output logic [COLS-1:0]  col_oe,
  output logic [NROWS-1:0] row_oe
);

  assign col_oe = {COLS{state == ST_CHARGE}};

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    assign row_oe[r] = (state == ST_DISCH) && (cur_row == RW'(r));
  end

endmodule

// File: rtl/rarray_scan.sv
module rarray_scan
  import rscan_pkg::*;
#(
  parameter int ROWS          = 8,
  parameter int COLS          = 8,
  parameter int TW            = 16,
  parameter int HAS_REF       = 1,
  parameter int CHARGE_CYCLES = 64,
  parameter int TIMEOUT       = 60000,
  localparam int NROWS = ROWS + HAS_REF,
  localparam int RW    = idx_width(NROWS),
  localparam int CW    = idx_width(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             continuous,
  input  logic [COLS-1:0]  col_in,
  output logic [COLS-1:0]  col_oe,
  output logic [NROWS-1:0] row_oe,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [RW-1:0]    m_row,
  output logic [CW-1:0]    m_col,
  output logic [TW-1:0]    m_count,
  output logic             m_timeout,
  output logic             frame_done
);

  // a column that never crossed reports full scale
  function automatic logic [TW-1:0] pick_count(input logic [TW-1:0] c, input logic h);
    return h ? c : {TW{1'b1}};
  endfunction

  scan_st_e      state;
  logic [RW-1:0] cur_row;
  logic [CW-1:0] cur_col;
  logic          tmr_clr;
  logic          tmr_en;
  logic [COLS-1:0] hit;
  logic [TW-1:0]   cnt [COLS];

  // named internal events
  logic all_hit;
  logic beat_fire;
  logic charge_phase;
  logic disch_phase;

  assign all_hit      = &hit;
  assign m_valid      = (state == ST_OUT);
  assign beat_fire    = m_valid && m_ready;
  assign charge_phase = (state == ST_CHARGE);
  assign disch_phase  = (state == ST_DISCH);

  rscan_ctrl #(
    .NROWS(NROWS), .COLS(COLS), .CHARGE_CYCLES(CHARGE_CYCLES), .TIMEOUT(TIMEOUT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .continuous(continuous),
    .all_hit(all_hit), .beat_fire(beat_fire), .state(state),
    .cur_row(cur_row), .cur_col(cur_col), .tmr_clr(tmr_clr),
    .tmr_en(tmr_en), .frame_done(frame_done)
  );

  rscan_pins #(.COLS(COLS), .NROWS(NROWS)) u_pins (
    .state(state), .cur_row(cur_row), .col_oe(col_oe), .row_oe(row_oe)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_tmr
    rscan_col_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en),
      .below(!col_in[c]), .cnt(cnt[c]), .hit(hit[c])
    );
  end

  assign m_row     = cur_row;
  assign m_col     = cur_col;
  assign m_count   = pick_count(cnt[cur_col], hit[cur_col]);
  assign m_timeout = !hit[cur_col];

endmodule

// File: rtl/rarray_scan_chk.sv
module rarray_scan_chk #(
  parameter int NROWS = 9,
  parameter int COLS  = 8,
  parameter int RW    = 4,
  parameter int CW    = 3,
  parameter int TW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [COLS-1:0]  col_oe,
  input logic [NROWS-1:0] row_oe,
  input logic             m_valid,
  input logic             m_ready,
  input logic [RW-1:0]    m_row,
  input logic [CW-1:0]    m_col,
  input logic [TW-1:0]    m_count,
  input logic             m_timeout,
  input logic             frame_done,
  input logic             charge_phase,
  input logic             disch_phase,
  input logic             beat_fire,
  input logic [RW-1:0]    cur_row
);

  localparam logic [RW-1:0] ROW_LAST = RW'(NROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  a_r2_charge_pins: assert property (@(posedge clk) disable iff (!rst_n)
    charge_phase |-> (&col_oe) && (row_oe == '0));

  a_r3_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    disch_phase |-> (col_oe == '0) && ($countones(row_oe) == 1) && row_oe[cur_row]);

  a_r3_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (!charge_phase && !disch_phase) |-> (col_oe == '0) && (row_oe == '0));

  a_r5_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_timeout) |-> (&m_count));

  a_r6_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && m_col != COL_LAST) |=> m_valid && (m_col == CW'($past(m_col) + 1'b1)));

  a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && m_col == COL_LAST && m_row != ROW_LAST) |=>
      !m_valid && (m_row == RW'($past(m_row) + 1'b1)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_row) && $stable(m_col)
                              && $stable(m_count) && $stable(m_timeout));

  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(beat_fire && m_row == ROW_LAST && m_col == COL_LAST));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

bind rarray_scan rarray_scan_chk #(
  .NROWS(NROWS), .COLS(COLS), .RW(RW), .CW(CW), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .col_oe(col_oe), .row_oe(row_oe),
  .m_valid(m_valid), .m_ready(m_ready), .m_row(m_row), .m_col(m_col),
  .m_count(m_count), .m_timeout(m_timeout), .frame_done(frame_done),
  .charge_phase(charge_phase), .disch_phase(disch_phase),
  .beat_fire(beat_fire), .cur_row(cur_row)
);

// File: tb/rarray_scan_tb.sv
module rarray_scan_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int HAS_REF = 1;
  localparam int NR = ROWS + HAS_REF;
  localparam int NB = NR * COLS;
  localparam int TW = 8;
  localparam int CHG = 3;
  localparam int TOUT = 20;

  // discharge delay per unit (row-major), and the result each must give
  localparam int DLY     [NB] = '{ 0, 5, 19, 20,   3, 3, 3, 3,   25, 1, 12, 7,   10, 10, 11, 9 };
  localparam int EXP_CNT [NB] = '{ 0, 5, 19, 255,  3, 3, 3, 3,   255, 1, 12, 7,  10, 10, 11, 9 };
  localparam int EXP_TO  [NB] = '{ 0, 0, 0, 1,     0, 0, 0, 0,   1, 0, 0, 0,     0, 0, 0, 0 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic continuous = 1'b0;
  logic [COLS-1:0] col_in = '1;
  logic [COLS-1:0] col_oe;
  logic [NR-1:0]   row_oe;
  logic m_valid;
  logic m_ready = 1'b1;
  logic [1:0] m_row;
  logic [1:0] m_col;
  logic [TW-1:0] m_count;
  logic m_timeout;
  logic frame_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  rarray_scan #(
    .ROWS(ROWS), .COLS(COLS), .TW(TW), .HAS_REF(HAS_REF),
    .CHARGE_CYCLES(CHG), .TIMEOUT(TOUT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .continuous(continuous),
    .col_in(col_in), .col_oe(col_oe), .row_oe(row_oe),
    .m_valid(m_valid), .m_ready(m_ready), .m_row(m_row), .m_col(m_col),
    .m_count(m_count), .m_timeout(m_timeout), .frame_done(frame_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit bp_en = 0;
  int cyc = 0;
  int bi = 0;
  int base = 0;
  int fd_cnt = 0;
  int v_hold = 0, v_fd = 0, v_chg = 0, v_row = 0;
  int e [COLS];
  bit pend = 0;
  bit hold = 0;
  int run = 0;
  logic [1:0] h_row, h_col;
  logic [TW-1:0] h_cnt;
  logic h_to;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // column model, ready pattern and stream monitor
  always @(negedge clk) begin
    int ridx;
    int rel;
    cyc++;
    ridx = -1;
    for (int r = 0; r < NR; r++) if (row_oe == (NR'(1) << r)) ridx = r;
    for (int c = 0; c < COLS; c++) begin
      if (col_oe[c]) begin
        e[c] = 0;
        col_in[c] = 1'b1;
      end else if (ridx >= 0) begin
        e[c] = e[c] + 1;
        col_in[c] = (e[c] > DLY[ridx*COLS + c]) ? 1'b0 : 1'b1;
      end
    end
    m_ready = !bp_en || (((cyc % 7) != 2) && ((cyc % 7) != 3));
    if (!rst_n) begin
      pend = 0; hold = 0; run = 0;
    end else begin
      rel = bi - base;
      // R7 payload held under backpressure
      if (hold && !(m_valid && m_row == h_row && m_col == h_col &&
                    m_count == h_cnt && m_timeout == h_to)) v_hold++;
      hold = m_valid && !m_ready;
      h_row = m_row; h_col = m_col; h_cnt = m_count; h_to = m_timeout;
      // R8 frame_done timing
      if (frame_done !== pend) v_fd++;
      if (frame_done) fd_cnt++;
      pend = m_valid && m_ready && m_row == 2'(NR-1) && m_col == 2'(COLS-1);
      // R2 charge length and pin state
      if (col_oe != '0 && col_oe != '1) v_chg++;
      if (col_oe == '1) begin
        run++;
        if (row_oe != '0) v_chg++;
      end else if (run != 0) begin
        if (run != CHG) v_chg++;
        run = 0;
      end
      // R3 only the row being measured is driven
      if (row_oe != '0) begin
        if (col_oe != '0 || ridx != ((rel / COLS) % NR)) v_row++;
      end
      // R4 R5 R6 R11 result beats
      if (m_valid && m_ready) begin
        int er, ec, ix;
        er = (rel / COLS) % NR;
        ec = rel % COLS;
        ix = er * COLS + ec;
        chk(m_row == 2'(er) && m_col == 2'(ec) && m_count == TW'(EXP_CNT[ix]) &&
            m_timeout == EXP_TO[ix][0],
            $sformatf("R4 R5 R6 R11 beat %0d row %0d/%0d col %0d/%0d to %0d/%0d count",
                      rel, m_row, er, m_col, ec, m_timeout, EXP_TO[ix]),
            m_count, EXP_CNT[ix]);
        bi++;
      end
    end
  end

  task automatic wait_fd(input int n);
    while (fd_cnt < n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int f0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(col_oe == '0 && row_oe == '0, "R1 pins during reset", {col_oe, row_oe}, 0);
    chk(!m_valid && !frame_done, "R1 stream during reset", {m_valid, frame_done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(col_oe == '0 && !m_valid, "R1 idle before start", {col_oe, m_valid}, 0);

    // single frame with backpressure, extra start mid-frame
    bp_en = 1;
    base = bi;
    pulse_start();
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_fd(1);
    repeat (30) @(negedge clk);
    chk(bi - base == NB, "R10 one frame of beats", bi - base, NB);
    chk(fd_cnt == 1, "R8 frame_done count", fd_cnt, 1);
    chk(col_oe == '0 && row_oe == '0 && !m_valid, "R9 idle after frame", {col_oe, m_valid}, 0);

    // continuous frames, drop continuous after the second
    continuous = 1'b1;
    base = bi;
    f0 = fd_cnt;
    pulse_start();
    wait_fd(f0 + 2);
    continuous = 1'b0;
    wait_fd(f0 + 3);
    repeat (30) @(negedge clk);
    chk(bi - base == 3 * NB, "R9 continuous beats", bi - base, 3 * NB);
    chk(fd_cnt == f0 + 3, "R9 frames in continuous run", fd_cnt, f0 + 3);
    chk(!m_valid && col_oe == '0, "R9 stop after continuous off", {m_valid, col_oe}, 0);

    // reset in the middle of a frame
    continuous = 1'b1;
    bp_en = 0;
    base = bi;
    pulse_start();
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(col_oe == '0 && row_oe == '0, "R1 pins after mid-frame reset", {col_oe, row_oe}, 0);
    chk(!m_valid && !frame_done, "R1 stream after mid-frame reset", {m_valid, frame_done}, 0);
    repeat (2) @(negedge clk);
    continuous = 1'b0;
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(col_oe == '0 && row_oe == '0 && !m_valid, "R9 waits for start after reset",
        {col_oe, m_valid}, 0);
    base = bi;
    f0 = fd_cnt;
    pulse_start();
    wait_fd(f0 + 1);
    repeat (20) @(negedge clk);
    chk(bi - base == NB, "R6 frame after reset", bi - base, NB);

    chk(v_hold == 0, "R7 payload stability", v_hold, 0);
    chk(v_fd == 0, "R8 frame_done timing", v_fd, 0);
    chk(v_chg == 0, "R2 charge phase pins and length", v_chg, 0);
    chk(v_row == 0, "R3 discharge row select", v_row, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule